// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. It holds three byte-wide registers: pending requests, lines in service, and a mask. It picks the most urgent unmasked request and compares it with the most urgent line already in service. When the processor acknowledges, it returns an 8-bit vector formed from a programmable base plus the line number. Software programs it through a byte-wide port with a single address bit. A start word at the even address restarts it, and a short series of words at the odd address follows. After that, odd-address writes load the mask and even-address writes are commands: end of interrupt, priority rotation, and choice of the register that reads return.

Two of these controllers can be chained. A master that acknowledges a line with a slave attached puts the line number on a 3-bit cascade bus instead of supplying a vector. A slave answers an acknowledge only when the cascade bus carries its own identity. The `slave_mode` input is a static strap that picks the role.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, the even address returns the request register (0x00 with idle inputs), `int_out` is low, the vector base is 0x00, inputs are edge-triggered, and line 7 has lowest priority (order 0,1,...,7).
- R2: An even-address write with bit 4 set restarts initialization. It sets the mask to 0xFF, clears the in-service and request registers, makes line 7 lowest, and selects the request register for reads. The next odd-address writes are then taken in order as vector base, cascade word, and (only when bit 0 of the start word was 1) the mode word. `int_out` stays low until the sequence ends.
- R3: Bit 3 of the start word set selects level-sensitive inputs, where a request follows its input and is raised again after acknowledge while the input stays high. Clear selects edge mode: a request is latched on a 0-to-1 input change, dropped when the input falls or the line is acknowledged, and needs a fresh rising edge to return.
- R4: One cycle after an accepted acknowledge, `vec_valid` is high for one cycle and `vec_out` is the base plus the line number, modulo 256.
- R5: After initialization an odd-address write loads the mask, and an odd-address read returns it. A mask bit of 1 keeps that line from raising `int_out` or winning an acknowledge.
- R6: An even-address command with bits 4:3 = 01 and bit 1 = 1 selects what even-address reads return: the in-service register when bit 0 is 1, the request register when bit 0 is 0. The choice holds until changed or until initialization restarts.
- R7: `int_out` is high when the highest-priority unmasked request ranks above every in-service line. An acknowledge sets that request's in-service bit, which drops `int_out` unless a still higher request is waiting.
- R8: An even-address command with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit. With bits 7:5 = 011 it clears the in-service bit that bits 2:0 name.
- R9: An even-address command with bits 4:3 = 00 and bits 7:5 = 110 makes the line in bits 2:0 lowest priority. For line 2 the order is 3,4,5,6,7,0,1,2. With bits 7:5 = 101, the highest-priority in-service bit is cleared and that line becomes lowest.
- R10: When bit 1 of the mode word is 1, an acknowledge returns the vector without setting any in-service bit.
- R11: An acknowledge that finds no request able to raise `int_out` returns the vector for line 7 (base plus 7) and leaves the in-service register unchanged.
- R12: A master (`slave_mode` = 0) that acknowledges a line whose bit is set in the cascade word drives `cas_out` with the line number and `cas_drive` high for one cycle instead of `vec_valid`. A slave (`slave_mode` = 1) accepts an acknowledge only when `cas_in` equals bits 2:0 of its cascade word. Otherwise the acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| addr | input | 1 | Register port address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request toward the processor |
| inta | input | 1 | Acknowledge strobe, one cycle |
| slave_mode | input | 1 | Role strap: 1 selects slave |
| cas_in | input | 3 | Cascade identity seen by a slave during acknowledge |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_drive | output | 1 | cas_out is valid this cycle |
| vec_out | output | 8 | Interrupt vector |
| vec_valid | output | 1 | vec_out is valid this cycle |

## Verification
The hardest case to reach is the spurious acknowledge. An edge-mode request has to raise `int_out` and then fall before the acknowledge arrives, so that the line-7 vector returns while the in-service register stays untouched. The stimulus drives a line high for exactly one cycle, drops it, and acknowledges on the next cycle. It then reads back the in-service register through the read-select command. Rotated priority with a lower-ranked line already in service is reached by setting the lowest line first. Two requests then race, and the loser is left pending under an in-service bit that outranks it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;

  // Rank of a line: 0 is most urgent, NL-1 is the lowest line itself.
  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] line,
                                            input logic [LW-1:0] low);
    return line - low - LW'(1);
  endfunction

  // Line that sits at a given rank.
  function automatic logic [LW-1:0] line_at(input logic [LW-1:0] rank,
                                            input logic [LW-1:0] low);
    return low + LW'(1) + rank;
  endfunction

  function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] base,
                                           input logic [LW-1:0] line);
    return base + DW'(line);
  endfunction

  function automatic logic [NL-1:0] onehot(input logic [LW-1:0] line);
    return NL'(1) << line;
  endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_mode,
  input  logic          init_clr,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] ack_clr,
  output logic [NL-1:0] irr
);
  logic [NL-1:0] prev_q;
  logic [NL-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      if (init_clr)
        irr <= '0;
      else if (level_mode)
        irr <= irq_in;
      else
        irr <= (irr | rise) & irq_in & ~ack_clr;
    end
  end

  // R3: in edge mode a request never appears without a rising edge
  p_edge_needs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !init_clr) |=> ((irr & ~$past(irr) & ~$past(rise)) == '0));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [NL-1:0] pend,
  input  logic [NL-1:0] isr,
  input  logic [LW-1:0] low,
  output logic          win_valid,
  output logic [LW-1:0] win_line,
  output logic          top_valid,
  output logic [LW-1:0] top_line,
  output logic          raise
);
  always_comb begin
    logic [LW-1:0] ln;
    win_valid = 1'b0;
    win_line  = '0;
    top_valid = 1'b0;
    top_line  = '0;
    for (int r = NL - 1; r >= 0; r--) begin
      ln = line_at(r[LW-1:0], low);
      if (pend[ln]) begin
        win_valid = 1'b1;
        win_line  = ln;
      end
      if (isr[ln]) begin
        top_valid = 1'b1;
        top_line  = ln;
      end
    end
  end

  assign raise = win_valid &&
                 (!top_valid || (rank_of(win_line, low) < rank_of(top_line, low)));
endmodule

// File: rtl/pic_isr.sv
module pic_isr
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic [NL-1:0] set_mask,
  input  logic [NL-1:0] clr_mask,
  output logic [NL-1:0] isr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      isr <= '0;
    else if (clr_all)
      isr <= '0;
    else
      isr <= (isr & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          top_valid,
  input  logic [LW-1:0] top_line,
  output logic [NL-1:0] imr,
  output logic [DW-1:0] base,
  output logic [NL-1:0] casc,
  output logic          aeoi,
  output logic          level,
  output logic [LW-1:0] low,
  output logic          sel_isr,
  output logic          ready,
  output logic          init_clr,
  output logic [NL-1:0] eoi_clr
);
  init_st_t    st_q;
  logic        need_mode_q;
  logic        is_ocw2, is_ocw3, odd_wr;
  logic [2:0]  cmd;

  assign ready    = (st_q == ST_RUN);
  assign cmd      = wdata[7:5];
  assign init_clr = wr_en && !addr && wdata[4];
  assign is_ocw3  = wr_en && !addr && !wdata[4] && wdata[3] && ready;
  assign is_ocw2  = wr_en && !addr && !wdata[4] && !wdata[3] && ready;
  assign odd_wr   = wr_en && addr;

  always_comb begin
    eoi_clr = '0;
    if (is_ocw2) begin
      if ((cmd == 3'b001 || cmd == 3'b101) && top_valid)
        eoi_clr = onehot(top_line);
      else if (cmd == 3'b011)
        eoi_clr = onehot(wdata[LW-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      need_mode_q <= 1'b0;
      imr         <= '1;
      base        <= '0;
      casc        <= '0;
      aeoi        <= 1'b0;
      level       <= 1'b0;
      low         <= LW'(NL - 1);
      sel_isr     <= 1'b0;
    end else if (init_clr) begin
      st_q        <= ST_BASE;
      need_mode_q <= wdata[0];
      level       <= wdata[3];
      imr         <= '1;
      aeoi        <= 1'b0;
      low         <= LW'(NL - 1);
      sel_isr     <= 1'b0;
    end else begin
      if (odd_wr) begin
        unique case (st_q)
          ST_BASE: begin base <= wdata; st_q <= ST_CASC; end
          ST_CASC: begin
            casc <= wdata;
            st_q <= need_mode_q ? ST_MODE : ST_RUN;
          end
          ST_MODE: begin aeoi <= wdata[1]; st_q <= ST_RUN; end
          default: imr <= wdata;
        endcase
      end
      if (is_ocw3 && wdata[1])
        sel_isr <= wdata[0];
      if (is_ocw2) begin
        if (cmd == 3'b110)
          low <= wdata[LW-1:0];
        else if (cmd == 3'b101 && top_valid)
          low <= top_line;
      end
    end
  end

  // R2: a restart leaves the mask fully set and reads on the request register
  p_restart_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (imr == '1 && !sel_isr && !ready));
  // R9: set-priority command moves the lowest line to the given level
  p_set_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ocw2 && cmd == 3'b110) |=> (low == $past(wdata[LW-1:0])));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] irq_in,
  output logic          int_out,
  input  logic          inta,
  input  logic          slave_mode,
  input  logic [LW-1:0] cas_in,
  output logic [LW-1:0] cas_out,
  output logic          cas_drive,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid
);
  logic [NL-1:0] irr, isr_q, imr, casc, eoi_clr, pend;
  logic [NL-1:0] isr_set, irr_clr, win_oh;
  logic [DW-1:0] base;
  logic [LW-1:0] low, win_line, top_line;
  logic          aeoi, level, sel_isr, ready, init_clr;
  logic          win_valid, top_valid, raise;
  logic          ack_take, ack_hit, ack_spur, route_slave;

  pic_cfg u_cfg (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .top_valid, .top_line,
    .imr, .base, .casc, .aeoi, .level, .low, .sel_isr,
    .ready, .init_clr, .eoi_clr
  );

  pic_req_latch u_req (
    .clk, .rst_n, .level_mode(level), .init_clr, .irq_in,
    .ack_clr(irr_clr), .irr
  );

  assign pend = irr & ~imr;

  pic_resolver u_res (
    .pend, .isr(isr_q), .low,
    .win_valid, .win_line, .top_valid, .top_line, .raise
  );

  pic_isr u_isr (
    .clk, .rst_n, .clr_all(init_clr), .set_mask(isr_set),
    .clr_mask(eoi_clr), .isr(isr_q)
  );

  assign int_out     = ready && raise;
  assign ack_take    = inta && ready && (!slave_mode || cas_in == casc[LW-1:0]);
  assign ack_hit     = ack_take && raise;
  assign ack_spur    = ack_take && !raise;
  assign win_oh      = onehot(win_line);
  assign isr_set     = (ack_hit && !aeoi) ? win_oh : '0;
  assign irr_clr     = ack_hit ? win_oh : '0;
  assign route_slave = ack_hit && !slave_mode && casc[win_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
      cas_out   <= '0;
      cas_drive <= 1'b0;
    end else begin
      vec_valid <= ack_take && !route_slave;
      cas_drive <= route_slave;
      if (route_slave)
        cas_out <= win_line;
      else if (ack_take)
        vec_out <= vec_of(base, ack_hit ? win_line : LW'(NL - 1));
    end
  end

  assign rdata = addr ? imr : (sel_isr ? isr_q : irr);

  // R4: a vector is only offered right after an accepted acknowledge
  p_vec_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_take));
  // R12: vector and cascade number are never offered together
  p_vec_cas_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_drive));
  // R7: acknowledge latches the winning line as in service
  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !aeoi && !wr_en) |=> isr_q[$past(win_line)]);
  // R10: automatic end of interrupt leaves the in-service register alone
  p_aeoi_keeps_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && aeoi && !wr_en) |=> $stable(isr_q));
  // R11: a spurious acknowledge does not touch the in-service register
  p_spur_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !wr_en) |=> $stable(isr_q));
  // R2: no interrupt is raised while initialization is in progress
  p_quiet_in_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ready);
  // R5: a fully masked controller raises nothing
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, inta = 1'b0, slave_mode = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [2:0] cas_in = 3'd0;
  logic [7:0] rdata, vec_out;
  logic [2:0] cas_out;
  logic       int_out, cas_drive, vec_valid;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .irq_in, .int_out,
    .inta, .slave_mode, .cas_in, .cas_out, .cas_drive, .vec_out, .vec_valid
  );

  // Behavioural reference state
  bit [7:0] m_irr, m_prev, m_isr, m_imr, m_base, m_casc, m_vec;
  int       m_low, m_st;
  bit       m_aeoi, m_level, m_sel, m_ic4, m_vv, m_cd;
  int       m_cas;
  int       m_win, m_top;
  bit       m_raise;

  task automatic m_reset();
    m_irr = 0; m_prev = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0; m_casc = 0;
    m_vec = 0; m_low = 7; m_st = 0; m_aeoi = 0; m_level = 0; m_sel = 0;
    m_ic4 = 0; m_vv = 0; m_cd = 0; m_cas = 0;
  endtask

  // Walk the priority order from most to least urgent.
  task automatic m_eval();
    int wk, ik, ln;
    bit [7:0] pend;
    pend = m_irr & ~m_imr;
    m_win = -1; m_top = -1; wk = 99; ik = 99;
    for (int k = 0; k < 8; k++) begin
      ln = (m_low + 1 + k) % 8;
      if (m_win < 0 && pend[ln]) begin m_win = ln; wk = k; end
      if (m_top < 0 && m_isr[ln]) begin m_top = ln; ik = k; end
    end
    m_raise = (m_win >= 0) && (wk < ik);
  endtask

  task automatic m_step();
    bit ready, take, hit, icw1, ocw2, ocw3;
    bit [7:0] n_irr, n_isr, clr, setm;
    int cmd;
    m_eval();
    ready = (m_st == 0);
    take  = inta && ready && (!slave_mode || cas_in == m_casc[2:0]);
    hit   = take && m_raise;
    icw1  = wr_en && !addr && wdata[4];
    ocw3  = wr_en && !addr && !wdata[4] && wdata[3] && ready;
    ocw2  = wr_en && !addr && !wdata[4] && !wdata[3] && ready;
    cmd   = wdata[7:5];
    clr = 0; setm = 0;
    if (ocw2 && (cmd == 1 || cmd == 5) && m_top >= 0) clr[m_top] = 1;
    if (ocw2 && cmd == 3) clr[wdata[2:0]] = 1;
    if (hit && !m_aeoi) setm[m_win] = 1;
    if (icw1) n_irr = 0;
    else if (m_level) n_irr = irq_in;
    else begin
      n_irr = (m_irr | (irq_in & ~m_prev)) & irq_in;
      if (hit) n_irr[m_win] = 0;
    end
    n_isr = icw1 ? 8'h00 : ((m_isr & ~clr) | setm);
    // outputs
    if (hit && !slave_mode && m_casc[m_win]) begin
      m_cd = 1; m_vv = 0; m_cas = m_win;
    end else begin
      m_cd = 0; m_vv = take;
      if (take) m_vec = m_base + (hit ? m_win : 7);
    end
    // configuration
    if (icw1) begin
      m_st = 1; m_ic4 = wdata[0]; m_level = wdata[3]; m_imr = 8'hFF;
      m_aeoi = 0; m_low = 7; m_sel = 0;
    end else begin
      if (wr_en && addr) begin
        case (m_st)
          1: begin m_base = wdata; m_st = 2; end
          2: begin m_casc = wdata; m_st = m_ic4 ? 3 : 0; end
          3: begin m_aeoi = wdata[1]; m_st = 0; end
          default: m_imr = wdata;
        endcase
      end
      if (ocw3 && wdata[1]) m_sel = wdata[0];
      if (ocw2 && cmd == 6) m_low = wdata[2:0];
      if (ocw2 && cmd == 5 && m_top >= 0) m_low = m_top;
    end
    m_prev = irq_in; m_irr = n_irr; m_isr = n_isr;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rdata();
    return addr ? m_imr : (m_sel ? m_isr : m_irr);
  endfunction

  task automatic compare_all();
    m_eval();
    chk("R7", "int_out", {7'd0, int_out}, {7'd0, m_raise && (m_st == 0)});
    chk("R4", "vec_valid", {7'd0, vec_valid}, {7'd0, m_vv});
    if (m_vv) chk("R4", "vec_out", vec_out, m_vec);
    chk("R12", "cas_drive", {7'd0, cas_drive}, {7'd0, m_cd});
    if (m_cd) chk("R12", "cas_out", {5'd0, cas_out}, 8'(m_cas));
    chk(addr ? "R5" : "R6", "rdata", rdata, m_rdata());
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic ack(input logic [2:0] c);
    inta = 1; cas_in = c;
    tick();
    inta = 0; cas_in = 0;
  endtask

  task automatic rd(input logic a, input string tag, input logic [7:0] exp);
    addr = a; #1;
    chk(tag, "read", rdata, exp);
    addr = 0; #1;
  endtask

  task automatic init4(input logic [7:0] w1, input logic [7:0] b,
                       input logic [7:0] c, input logic [7:0] m);
    wr(0, w1); wr(1, b); wr(1, c); wr(1, m);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    rd(1, "R1", 8'hFF);
    rd(0, "R1", 8'h00);
    chk("R1", "int_out", {7'd0, int_out}, 8'h00);
    tick();

    // R2: init, edge, with mode word; slave on line 2
    wr(0, 8'h11);
    wr(1, 8'h20);
    chk("R2", "int quiet in init", {7'd0, int_out}, 8'h00);
    wr(1, 8'h04); wr(1, 8'h01);
    rd(1, "R2", 8'hFF);
    // R5: mask write
    wr(1, 8'h00);
    rd(1, "R5", 8'h00);

    // R4, R7: line 3
    irq_in = 8'h08; tick();
    chk("R7", "int raised", {7'd0, int_out}, 8'h01);
    ack(0);
    chk("R4", "vector line 3", vec_out, 8'h23);
    chk("R7", "int dropped", {7'd0, int_out}, 8'h00);
    // higher line 1 preempts
    irq_in = 8'h0A; tick();
    chk("R7", "higher raises", {7'd0, int_out}, 8'h01);
    ack(0);
    chk("R4", "vector line 1", vec_out, 8'h21);
    // R6: select in-service
    wr(0, 8'h0B);
    rd(0, "R6", 8'h0A);
    // R8: non-specific then specific
    wr(0, 8'h20);
    rd(0, "R8", 8'h08);
    wr(0, 8'h63);
    rd(0, "R8", 8'h00);
    // R3: edge line held high does not return
    tick();
    chk("R3", "edge no retrigger", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; tick();

    // R5: masked line
    wr(1, 8'h10);
    irq_in = 8'h10; tick(); tick();
    chk("R5", "masked no int", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; wr(1, 8'h00);

    // R9: line 2 lowest, order 3..7,0,1,2
    wr(0, 8'hC2);
    irq_in = 8'h0A; tick();
    ack(0);
    chk("R9", "rotated winner 3", vec_out, 8'h23);
    chk("R9", "line 1 outranked", {7'd0, int_out}, 8'h00);
    wr(0, 8'hA0);      // rotate on EOI: line 3 becomes lowest
    chk("R9", "line 1 after rotate", {7'd0, int_out}, 8'h01);
    ack(0);
    chk("R9", "vector line 1", vec_out, 8'h21);
    rd(0, "R9", 8'h02);
    wr(0, 8'h20);
    irq_in = 8'h00; tick();

    // R11: spurious
    irq_in = 8'h20; tick();
    irq_in = 8'h00; tick();
    ack(0);
    chk("R11", "spurious vector", vec_out, 8'h27);
    rd(0, "R11", 8'h00);

    // R12: master routes line 2 to slave
    irq_in = 8'h04; tick();
    ack(0);
    chk("R12", "cas_drive", {7'd0, cas_drive}, 8'h01);
    chk("R12", "cas_out", {5'd0, cas_out}, 8'h02);
    chk("R12", "no vector", {7'd0, vec_valid}, 8'h00);
    wr(0, 8'h20);
    irq_in = 8'h00; tick();

    // R3, R10: level with automatic EOI
    init4(8'h19, 8'h40, 8'h04, 8'h03);
    rd(0, "R6", 8'h00);
    wr(1, 8'h00);
    irq_in = 8'h40; tick();
    ack(0);
    chk("R10", "vector line 6", vec_out, 8'h46);
    wr(0, 8'h0B);
    rd(0, "R10", 8'h00);
    chk("R3", "level re-raises", {7'd0, int_out}, 8'h01);
    irq_in = 8'h00; tick();
    chk("R3", "level drops", {7'd0, int_out}, 8'h00);

    // R12: slave identity 5
    slave_mode = 1;
    init4(8'h11, 8'h70, 8'h05, 8'h01);
    wr(1, 8'h00);
    irq_in = 8'h01; tick();
    ack(3'd3);
    chk("R12", "other id ignored", {7'd0, vec_valid}, 8'h00);
    chk("R12", "still pending", {7'd0, int_out}, 8'h01);
    ack(3'd5);
    chk("R12", "own id vector", vec_out, 8'h70);
    irq_in = 8'h00; tick(); tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule